// File: doc/BRIEF.md
# Video Active-Region Auto-Position Detector

This block sits in the pixel clock domain. It watches a stream of 8-bit luma samples that arrive with their horizontal and vertical sync flags, and it finds where the visible picture lies inside each input frame. A sample whose luma reaches a programmable brightness threshold is treated as picture. Any darker sample is treated as blanking. From this the block reports the first and last active pixel column, the first and last active line, the measured line length in samples, and the width of the horizontal sync pulse. A display controller uses these values to centre and scale the picture.

Two detection modes exist. In single-line mode, the horizontal extent is measured on one selected line and the vertical extent on one selected column. Both selectors count in steps of 8. In whole-frame mode, the earliest start and the latest end over the entire frame are kept. The vertical direction may use its own threshold.

Samples enter on a valid/ready stream. `s_ready` is held high at all times, so the block never applies back-pressure. A sample counts only in a cycle where `s_valid` is high. While `s_valid` is low, nothing advances, whatever the other inputs carry. Results are register outputs that change only at the start of a frame.

Top module: `avd_top`

## Requirements
- R1: A sample is active when its luma is greater than or equal to the threshold in force, and blanking when its luma is below it. A luma exactly equal to the threshold is active.
- R2: With `cfg_vthresh_en` = 1, the vertical extent uses `cfg_vthresh`. With `cfg_vthresh_en` = 0, the vertical extent uses `cfg_hthresh`. The horizontal extent always uses `cfg_hthresh`.
- R3: With `cfg_whole_frame` = 0, `h_start`/`h_end` come only from samples on line number `cfg_hline_sel`*8.
- R4: With `cfg_whole_frame` = 0, `v_start`/`v_end` come only from samples in column `cfg_vcol_sel`*8.
- R5: With `cfg_whole_frame` = 1, the results are the smallest start and the largest end over all active samples of the frame. A published start that is not all-ones never exceeds its end.
- R6: Results change only on an accepted sample where `s_vsync` rises; at that sample the previous frame is published. A direction with no active sample reports start 7FFh and end 0.
- R7: Positions are counted as follows.
  - Column 0 is the accepted sample on which `s_hsync` rises.
  - Line 0 is the line on which `s_vsync` rises.
  - Each further `s_hsync` rise advances the line number by one.
  - `h_total` is the number of accepted samples from one `s_hsync` rise to the next, for the last full line before publication.
- R8: `hs_width` is the number of accepted samples with `s_hsync` high in the last sync pulse, saturating at 255.
- R9: Samples with `s_valid` low are ignored; all outputs equal those of the same stream without the idle cycles.
- R10: After reset, `h_start` = `v_start` = 7FFh, `h_end` = `v_end` = `h_total` = `hs_width` = 0, and `s_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Always 1, no back-pressure |
| s_luma | input | 8 | Luma of the sample |
| s_hsync | input | 1 | Horizontal sync, active high |
| s_vsync | input | 1 | Vertical sync, active high |
| cfg_whole_frame | input | 1 | 1: whole-frame mode, 0: single-line mode |
| cfg_hthresh | input | 8 | Horizontal (and shared) threshold |
| cfg_vthresh | input | 8 | Separate vertical threshold |
| cfg_vthresh_en | input | 1 | Selects `cfg_vthresh` for the vertical direction |
| cfg_hline_sel | input | 8 | Line for horizontal detection, units of 8 lines |
| cfg_vcol_sel | input | 8 | Column for vertical detection, units of 8 samples |
| h_start | output | 11 | First active column |
| h_end | output | 11 | Last active column |
| v_start | output | 11 | First active line |
| v_end | output | 11 | Last active line |
| h_total | output | 11 | Samples per line |
| hs_width | output | 8 | Horizontal sync width in samples |

## Verification
The assertions check several properties on every cycle:
- the published results stay frozen between frame starts;
- the position counters hold still on idle cycles;
- the sync-width counter stays at its ceiling once saturated;
- a published start never passes its end.

Only the bench's frame scenarios can show that the extents land on the right columns and lines. The same applies to threshold equality, the vertical threshold select, the single-line and single-column selectors, and the line length. For idle cycles, the bench injects stray sync and luma values while `s_valid` is low and expects the same results as for the clean stream.

// File: rtl/avd_pkg.sv
`timescale 1ns/1ps
package avd_pkg;
  localparam int POS_W     = 11;
  localparam int LUMA_W    = 8;
  localparam int HSW_W     = 8;
  localparam int SEL_W     = 8;
  localparam int SEL_SHIFT = 3;
  localparam int N_AXIS    = 2;
  localparam int AXIS_H    = 0;
  localparam int AXIS_V    = 1;
endpackage

// File: rtl/avd_sync_track.sv
`timescale 1ns/1ps
module avd_sync_track #(
  parameter int POS_W = avd_pkg::POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hsync,
  input  logic             vsync,
  output logic             hrise,
  output logic             hfall,
  output logic             vrise,
  output logic [POS_W-1:0] x_new,
  output logic [POS_W-1:0] y_new,
  output logic [POS_W-1:0] x_prev
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic             hs_q, vs_q;
  logic [POS_W-1:0] x_q, y_q, x_inc, y_inc;

  assign hrise  = en & hsync & ~hs_q;
  assign hfall  = en & ~hsync & hs_q;
  assign vrise  = en & vsync & ~vs_q;
  assign x_inc  = (x_q == POS_MAX) ? x_q : x_q + POS_W'(1);
  assign y_inc  = (y_q == POS_MAX) ? y_q : y_q + POS_W'(1);
  assign x_new  = hrise ? '0 : x_inc;
  assign y_new  = vrise ? '0 : (hrise ? y_inc : y_q);
  assign x_prev = x_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
    end else if (en) begin
      hs_q <= hsync;
      vs_q <= vsync;
      x_q  <= x_new;
      y_q  <= y_new;
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(x_q) && $stable(y_q)));
endmodule

// File: rtl/avd_line_meas.sv
`timescale 1ns/1ps
module avd_line_meas #(
  parameter int POS_W = avd_pkg::POS_W,
  parameter int HSW_W = avd_pkg::HSW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hsync,
  input  logic             hrise,
  input  logic             hfall,
  input  logic             frame_start,
  input  logic [POS_W-1:0] x_prev,
  output logic [POS_W-1:0] h_total,
  output logic [HSW_W-1:0] hs_width
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [HSW_W-1:0] HSW_MAX = {HSW_W{1'b1}};

  logic [POS_W-1:0] len_q, len_next;
  logic [HSW_W-1:0] hw_q, hw_next, cap_q, cap_next;

  assign len_next = hrise ? ((x_prev == POS_MAX) ? x_prev : x_prev + POS_W'(1)) : len_q;
  assign cap_next = hfall ? hw_q : cap_q;

  always_comb begin
    hw_next = hw_q;
    if (hrise)
      hw_next = HSW_W'(1);
    else if (en && hsync && hw_q != HSW_MAX)
      hw_next = hw_q + HSW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      hw_q     <= '0;
      cap_q    <= '0;
      h_total  <= '0;
      hs_width <= '0;
    end else if (en) begin
      len_q <= len_next;
      hw_q  <= hw_next;
      cap_q <= cap_next;
      if (frame_start) begin
        h_total  <= len_next;
        hs_width <= cap_next;
      end
    end
  end

  // R8
  width_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hsync && !hrise && hw_q == HSW_MAX) |=> (hw_q == HSW_MAX));
endmodule

// File: rtl/avd_extent.sv
`timescale 1ns/1ps
module avd_extent #(
  parameter int POS_W = avd_pkg::POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frame_start,
  input  logic             hit,
  input  logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] ext_start,
  output logic [POS_W-1:0] ext_end
);
  localparam logic [POS_W-1:0] NONE = {POS_W{1'b1}};

  logic [POS_W-1:0] acc_s, acc_e, base_s, base_e;

  assign base_s = frame_start ? NONE : acc_s;
  assign base_e = frame_start ? '0   : acc_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_s     <= NONE;
      acc_e     <= '0;
      ext_start <= NONE;
      ext_end   <= '0;
    end else if (en) begin
      acc_s <= (hit && pos < base_s) ? pos : base_s;
      acc_e <= (hit && pos > base_e) ? pos : base_e;
      if (frame_start) begin
        ext_start <= acc_s;
        ext_end   <= acc_e;
      end
    end
  end

  // R5
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_start != NONE) |-> (ext_start <= ext_end));
endmodule

// File: rtl/avd_top.sv
`timescale 1ns/1ps
module avd_top
  import avd_pkg::*;
#(
  parameter int P_POS_W  = POS_W,
  parameter int P_LUMA_W = LUMA_W,
  parameter int P_HSW_W  = HSW_W,
  parameter int P_SEL_W  = SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [P_LUMA_W-1:0] s_luma,
  input  logic                s_hsync,
  input  logic                s_vsync,
  input  logic                cfg_whole_frame,
  input  logic [P_LUMA_W-1:0] cfg_hthresh,
  input  logic [P_LUMA_W-1:0] cfg_vthresh,
  input  logic                cfg_vthresh_en,
  input  logic [P_SEL_W-1:0]  cfg_hline_sel,
  input  logic [P_SEL_W-1:0]  cfg_vcol_sel,
  output logic [P_POS_W-1:0]  h_start,
  output logic [P_POS_W-1:0]  h_end,
  output logic [P_POS_W-1:0]  v_start,
  output logic [P_POS_W-1:0]  v_end,
  output logic [P_POS_W-1:0]  h_total,
  output logic [P_HSW_W-1:0]  hs_width
);
  localparam int SELPOS_W = P_SEL_W + SEL_SHIFT;

  logic                hrise, hfall, vrise;
  logic [P_POS_W-1:0]  x_new, y_new, x_prev;
  logic [P_POS_W-1:0]  hline_pos, vcol_pos;
  logic [P_LUMA_W-1:0] v_thresh;
  logic [N_AXIS-1:0]   hit;
  logic [P_POS_W-1:0]  pos_arr   [N_AXIS];
  logic [P_POS_W-1:0]  start_arr [N_AXIS];
  logic [P_POS_W-1:0]  end_arr   [N_AXIS];

  assign s_ready   = 1'b1;
  assign v_thresh  = cfg_vthresh_en ? cfg_vthresh : cfg_hthresh;
  assign hline_pos = P_POS_W'({cfg_hline_sel, {SEL_SHIFT{1'b0}}});
  assign vcol_pos  = P_POS_W'({cfg_vcol_sel,  {SEL_SHIFT{1'b0}}});

  assign hit[AXIS_H] = s_valid && (s_luma >= cfg_hthresh) &&
                       (cfg_whole_frame || y_new == hline_pos);
  assign hit[AXIS_V] = s_valid && (s_luma >= v_thresh) &&
                       (cfg_whole_frame || x_new == vcol_pos);
  assign pos_arr[AXIS_H] = x_new;
  assign pos_arr[AXIS_V] = y_new;

  avd_sync_track #(.POS_W(P_POS_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(s_valid), .hsync(s_hsync), .vsync(s_vsync),
    .hrise(hrise), .hfall(hfall), .vrise(vrise),
    .x_new(x_new), .y_new(y_new), .x_prev(x_prev)
  );

  avd_line_meas #(.POS_W(P_POS_W), .HSW_W(P_HSW_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .en(s_valid), .hsync(s_hsync),
    .hrise(hrise), .hfall(hfall), .frame_start(vrise), .x_prev(x_prev),
    .h_total(h_total), .hs_width(hs_width)
  );

  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    avd_extent #(.POS_W(P_POS_W)) u_ext (
      .clk(clk), .rst_n(rst_n), .en(s_valid), .frame_start(vrise),
      .hit(hit[a]), .pos(pos_arr[a]),
      .ext_start(start_arr[a]), .ext_end(end_arr[a])
    );
  end

  assign h_start = start_arr[AXIS_H];
  assign h_end   = end_arr[AXIS_H];
  assign v_start = start_arr[AXIS_V];
  assign v_end   = end_arr[AXIS_V];

  // R6
  publish_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vrise |=> ($stable(h_start) && $stable(h_end) && $stable(v_start) &&
                $stable(v_end) && $stable(h_total) && $stable(hs_width)));

  initial begin
    // R7
    sel_fit_chk: assert (SELPOS_W <= P_POS_W);
  end
endmodule

// File: tb/avd_top_tb.sv
`timescale 1ns/1ps
module avd_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_luma = '0;
  logic        s_hsync = 1'b0, s_vsync = 1'b0;
  logic        cfg_whole_frame = 1'b1;
  logic [7:0]  cfg_hthresh = 8'h20, cfg_vthresh = 8'h00;
  logic        cfg_vthresh_en = 1'b0;
  logic [7:0]  cfg_hline_sel = 8'h06, cfg_vcol_sel = 8'h37;
  logic [10:0] h_start, h_end, v_start, v_end, h_total;
  logic [7:0]  hs_width;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  avd_top dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_luma(s_luma), .s_hsync(s_hsync), .s_vsync(s_vsync),
    .cfg_whole_frame(cfg_whole_frame), .cfg_hthresh(cfg_hthresh),
    .cfg_vthresh(cfg_vthresh), .cfg_vthresh_en(cfg_vthresh_en),
    .cfg_hline_sel(cfg_hline_sel), .cfg_vcol_sel(cfg_vcol_sel),
    .h_start(h_start), .h_end(h_end), .v_start(v_start), .v_end(v_end),
    .h_total(h_total), .hs_width(hs_width)
  );

  // fields: line len, lines, sync width, x0, x1, y0, y1, luma, dot x, dot y,
  // whole, hth, vth, ven, hsel, vsel, exp hs, he, vs, ve, htot, hsw, gap
  localparam int NV = 11;
  localparam int NF = 23;
  localparam int VEC [NV][NF] = '{
    '{24,20,3, 5,17,3,12,128, 10,5, 1, 32,  0,0, 6,55,    5,  17,   3,12,24,3, 0}, // R1
    '{24,20,3, 5,17,3,12,128, 10,5, 1,144,  0,0, 6,55, 2047,   0,2047, 0,24,3, 0}, // R1 R6
    '{24,20,3, 5,17,3,12,128, 10,5, 1,128,  0,0, 6,55,    5,  17,   3,12,24,3, 0}, // R1 equal
    '{24,20,3, 5,17,3,12,128, 10,5, 1, 32,144,1, 6,55,    5,  17,2047, 0,24,3, 0}, // R2
    '{24,20,3, 5,17,3,12,128, 10,5, 1, 32,144,0, 6,55,    5,  17,   3,12,24,3, 0}, // R2
    '{24,20,3, 5,17,3,12,128, 20,1, 1, 32,  0,0, 1, 1,    5,  20,   1,12,24,3, 0}, // R5
    '{24,20,3, 5,17,3,12,128, 20,1, 0, 32,  0,0, 1, 1,    5,  17,   3,12,24,3, 0}, // R3 R4
    '{24,20,3, 5,17,3,12,128, 10,5, 0, 32,  0,0, 2, 0, 2047,   0,2047, 0,24,3, 0}, // R3 R4
    '{24,20,3, 5,17,3,12,128, 16,15,0, 32,  0,0, 1, 2,    5,  17,   3,15,24,3, 0}, // R4
    '{30,20,5, 2,28,0,19,128, 10,5, 1, 32,  0,0, 6,55,    2,  28,   0,19,30,5, 0}, // R7
    '{24,20,3, 5,17,3,12,128, 10,5, 1, 32,  0,0, 6,55,    5,  17,   3,12,24,3, 1}  // R9
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic hs, input logic vs, input logic [7:0] lu, input bit gap);
    @(negedge clk);
    s_valid = 1'b1; s_hsync = hs; s_vsync = vs; s_luma = lu;
    if (gap) begin
      @(negedge clk);
      s_valid = 1'b0; s_hsync = ~hs; s_vsync = 1'b1; s_luma = 8'hFF;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 1'b0; s_hsync = 1'b0; s_vsync = 1'b0; s_luma = '0;
  endtask

  task automatic run_frame(input int v);
    for (int y = 0; y < VEC[v][1]; y++) begin
      for (int x = 0; x < VEC[v][0]; x++) begin
        bit in_rect;
        bit on_dot;
        in_rect = x >= VEC[v][3] && x <= VEC[v][4] && y >= VEC[v][5] && y <= VEC[v][6];
        on_dot  = x == VEC[v][8] && y == VEC[v][9];
        put(x < VEC[v][2], y == 0, (in_rect || on_dot) ? 8'(VEC[v][7]) : 8'h00, VEC[v][22] != 0);
      end
    end
  endtask

  task automatic flush();
    put(1'b1, 1'b1, 8'h00, 1'b0);
    put(1'b0, 1'b0, 8'h00, 1'b0);
    idle();
  endtask

  task automatic check_all(input string tag, input int hs, input int he,
                           input int vs, input int ve, input int ht, input int hw);
    check({tag, " h_start"},  int'(h_start),  hs);
    check({tag, " h_end"},    int'(h_end),    he);
    check({tag, " v_start"},  int'(v_start),  vs);
    check({tag, " v_end"},    int'(v_end),    ve);
    check({tag, " h_total"},  int'(h_total),  ht);
    check({tag, " hs_width"}, int'(hs_width), hw);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check_all("R10 reset", 2047, 0, 2047, 0, 0, 0);
    check("R10 s_ready", int'(s_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      cfg_whole_frame = VEC[v][10] != 0;
      cfg_hthresh     = 8'(VEC[v][11]);
      cfg_vthresh     = 8'(VEC[v][12]);
      cfg_vthresh_en  = VEC[v][13] != 0;
      cfg_hline_sel   = 8'(VEC[v][14]);
      cfg_vcol_sel    = 8'(VEC[v][15]);
      run_frame(v);
      flush();
      check_all($sformatf("vec%0d R1 R2 R3 R4 R5 R7", v),
                VEC[v][16], VEC[v][17], VEC[v][18], VEC[v][19], VEC[v][20], VEC[v][21]);
      if (v == 0) begin
        // R6: bright lines without a vsync rise must not touch the outputs
        for (int y = 0; y < 2; y++)
          for (int x = 0; x < 24; x++)
            put(x < 3, 1'b0, 8'hFF, 1'b0);
        idle();
        repeat (5) @(negedge clk);
        check_all("R6 hold", 5, 17, 3, 12, 24, 3);
      end
    end

    // R8 saturating sync width, long line
    cfg_whole_frame = 1'b1;
    cfg_hthresh     = 8'h20;
    cfg_vthresh_en  = 1'b0;
    for (int y = 0; y < 2; y++)
      for (int x = 0; x < 320; x++)
        put(x < 300, y == 0, 8'h00, 1'b0);
    flush();
    check("R8 hs_width", int'(hs_width), 255);
    check("R7 h_total 320", int'(h_total), 320);
    check("R6 empty h_start", int'(h_start), 2047);
    check("R6 empty v_end", int'(v_end), 0);

    // R10 reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R10 re-reset", 2047, 0, 2047, 0, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule